// File: doc/BRIEF.md
# Dual-Strobe BCD Up/Down Decade Counter

This block holds one decimal digit (0 to 9) and steps it with two independent count strobes instead of a clock plus direction pin. A rising edge on the up strobe advances the digit while the down strobe rests high. A rising edge on the down strobe retreats it while the up strobe rests high. Both strobes are asynchronous to the system clock. Each passes through a two-flop synchronizer, and its rising edge is found in the system clock domain.

An active-high clear forces the digit to zero and takes priority over everything else. An active-low load copies a 4-bit word into the digit. Two active-low terminal outputs mirror the low phase of the active strobe. carry_n mirrors the up strobe when the digit sits at nine, and borrow_n mirrors the down strobe when the digit sits at zero. Because of this, they can feed the strobe inputs of a following digit directly.

A synchronous active-high reset brings the whole block, including the synchronizers, to its idle state.

Top module: `bcd_updown_digit`

## Requirements
- R1: A synchronized rising edge of up_stb while dn_stb is high adds one to count. The count changes on the third rising clk edge after up_stb goes high.
- R2: A synchronized rising edge of dn_stb while up_stb is high subtracts one from count. It has the same three-edge latency as R1.
- R3: Stepping up from 9 gives 0, and stepping down from 0 gives 9.
- R4: While clear is high, count becomes 0 on the next clk edge. This holds whatever the values of load_n, data_in and the strobes.
- R5: While clear is low and load_n is low, count takes data_in on the next clk edge. This holds whatever the strobes do.
- R6: carry_n is low exactly when count is 9 and the synchronized up_stb is low (two clk edges after the pin falls). Otherwise it is high.
- R7: borrow_n is low exactly when count is 0 and the synchronized dn_stb is low. Otherwise it is high.
- R8: A strobe that is low during a clear or load and remains low afterwards has its next rising edge counted as a normal step.
- R9: If both strobes rise in the same clock cycle, count does not change. It also does not change if one strobe rises while the other is low.
- R10: From a loaded non-decimal value (10 to 15), an up step gives 0 and a down step gives the value minus one. carry_n and borrow_n stay high at those values.
- R11: After reset, count is 0 and carry_n and borrow_n are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| up_stb | input | 1 | Up count strobe, asynchronous, idles high |
| dn_stb | input | 1 | Down count strobe, asynchronous, idles high |
| load_n | input | 1 | Active-low parallel preset |
| clear | input | 1 | Active-high clear to zero |
| data_in | input | 4 | Preset value |
| count | output | 4 | Current digit value |
| carry_n | output | 1 | Active-low carry, mirrors up strobe at 9 |
| borrow_n | output | 1 | Active-low borrow, mirrors down strobe at 0 |

## Verification
A wrong digit register is seen at count on the very next clock edge. The terminal flags decode that register, so a wrong digit also shows up as a wrong or missing carry_n or borrow_n pulse during the next strobe low phase.

A synchronizer or edge-detector fault does not appear until a strobe moves. It then shows as a missing, doubled or misdirected step three edges after the strobe rises, or as a flag that fails to track the strobe two edges after it falls. The directed scenarios place strobe transitions around loads, clears and both terminal values so that each of these delays is observed at a known cycle.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stb_in,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Stages reset high: the idle level of a strobe, so reset creates no edge.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= stb_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/step_arbiter.sv
module step_arbiter
  import bcd_digit_pkg::*;
(
  input  logic  up_rise,
  input  logic  up_level,
  input  logic  dn_rise,
  input  logic  dn_level,
  output step_e step_o
);
  always_comb begin
    step_o = STEP_HOLD;
    if (up_rise && !dn_rise && dn_level)      step_o = STEP_UP;
    else if (dn_rise && !up_rise && up_level) step_o = STEP_DOWN;
  end
endmodule

// File: rtl/digit_reg.sv
module digit_reg
  import bcd_digit_pkg::*;
#(
  parameter int TOP_VAL = 9
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   clear,
  input  logic   load_n,
  input  digit_t data_in,
  input  step_e  step,
  output digit_t count_o
);
  localparam digit_t TOP_D = digit_t'(TOP_VAL);
  digit_t cnt_q;
  digit_t cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)        cnt_d = '0;
    else if (!load_n) cnt_d = data_in;
    else begin
      case (step)
        STEP_UP:   cnt_d = (cnt_q >= TOP_D) ? '0 : cnt_q + digit_t'(1);
        STEP_DOWN: cnt_d = (cnt_q == '0) ? TOP_D : cnt_q - digit_t'(1);
        default:   cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/term_detect.sv
module term_detect
  import bcd_digit_pkg::*;
#(
  parameter int TOP_VAL = 9
) (
  input  digit_t count,
  input  logic   up_level,
  input  logic   dn_level,
  output logic   carry_n,
  output logic   borrow_n
);
  localparam digit_t TOP_D = digit_t'(TOP_VAL);
  assign carry_n  = ~((count == TOP_D) & ~up_level);
  assign borrow_n = ~((count == '0) & ~dn_level);
endmodule

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit
  import bcd_digit_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TOP_VAL     = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_stb,
  input  logic         dn_stb,
  input  logic         load_n,
  input  logic         clear,
  input  logic [3:0]   data_in,
  output logic [3:0]   count,
  output logic         carry_n,
  output logic         borrow_n
);
  logic  up_level, up_rise, dn_level, dn_rise;
  step_e step;
  digit_t cnt;

  strobe_sync #(.STAGES(SYNC_STAGES)) i_up_sync (
    .clk(clk), .rst(rst), .stb_in(up_stb), .level_o(up_level), .rise_o(up_rise)
  );
  strobe_sync #(.STAGES(SYNC_STAGES)) i_dn_sync (
    .clk(clk), .rst(rst), .stb_in(dn_stb), .level_o(dn_level), .rise_o(dn_rise)
  );
  step_arbiter i_arb (
    .up_rise(up_rise), .up_level(up_level),
    .dn_rise(dn_rise), .dn_level(dn_level), .step_o(step)
  );
  digit_reg #(.TOP_VAL(TOP_VAL)) i_digit (
    .clk(clk), .rst(rst), .clear(clear), .load_n(load_n),
    .data_in(data_in), .step(step), .count_o(cnt)
  );
  term_detect #(.TOP_VAL(TOP_VAL)) i_term (
    .count(cnt), .up_level(up_level), .dn_level(dn_level),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );

  assign count = cnt;
endmodule

// File: rtl/bcd_updown_digit_chk.sv
module bcd_updown_digit_chk (
  input logic       clk,
  input logic       rst,
  input logic       load_n,
  input logic       clear,
  input logic [3:0] data_in,
  input logic [3:0] count,
  input logic       carry_n,
  input logic       borrow_n
);
  function automatic logic [3:0] inc_of(input logic [3:0] v);
    return (v >= 4'd9) ? 4'd0 : v + 4'd1;
  endfunction
  function automatic logic [3:0] dec_of(input logic [3:0] v);
    return (v == 4'd0) ? 4'd9 : v - 4'd1;
  endfunction

  // R4
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> count == 4'd0);
  // R5
  a_r5_load_copies: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load_n) |=> count == $past(data_in));
  // R1 R2 R3: outside clear and load the digit moves by one step at most
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clear) && $past(load_n) && count != $past(count))
      |-> (count == inc_of($past(count)) || count == dec_of($past(count))));
  // R6
  a_r6_carry_at_nine: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> count == 4'd9);
  // R7
  a_r7_borrow_at_zero: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> count == 4'd0);
  // R10
  a_r10_nonbcd_flags: assert property (@(posedge clk) disable iff (rst)
    (count > 4'd9) |-> (carry_n && borrow_n));
endmodule

bind bcd_updown_digit bcd_updown_digit_chk i_chk (
  .clk(clk), .rst(rst), .load_n(load_n), .clear(clear),
  .data_in(data_in), .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
);

// File: tb/test_bcd_updown_digit.sv
`timescale 1ns/1ps
module test_bcd_updown_digit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up_stb = 1'b1, dn_stb = 1'b1, load_n = 1'b1, clear = 1'b0;
  logic [3:0] data_in = 4'd0;
  logic [3:0] count;
  logic       carry_n, borrow_n;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_updown_digit i_bcd_updown_digit (
    .clk(clk), .rst(rst), .up_stb(up_stb), .dn_stb(dn_stb), .load_n(load_n),
    .clear(clear), .data_in(data_in), .count(count),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_val(input logic [3:0] v);
    load_n = 1'b0; data_in = v; tick(1);
    check("R5 load", count, v);
    load_n = 1'b1;
  endtask

  // Up step; flag checks during the low phase
  task automatic up_step(input int exp, input string req);
    up_stb = 1'b0; tick(2);
    check("R6 carry low phase", carry_n, (count == 4'd9) ? 0 : 1);
    tick(1);
    up_stb = 1'b1; tick(2);
    check("R6 carry released", carry_n, 1);
    tick(1);
    check(req, count, exp);
  endtask

  task automatic dn_step(input int exp, input string req);
    dn_stb = 1'b0; tick(2);
    check("R7 borrow low phase", borrow_n, (count == 4'd0) ? 0 : 1);
    tick(1);
    dn_stb = 1'b1; tick(3);
    check(req, count, exp);
  endtask

  task automatic t_reset;
    check("R11 count", count, 0);
    check("R11 carry_n", carry_n, 1);
    check("R11 borrow_n", borrow_n, 1);
  endtask

  task automatic t_sequence;
    clear = 1'b1; tick(1); check("R4 clear", count, 0); clear = 1'b0;
    load_val(4'd7);
    up_step(8, "R1 up");
    up_step(9, "R1 up");
    up_step(0, "R3 wrap up");
    up_step(1, "R1 up");
    up_step(2, "R1 up");
    dn_step(1, "R2 down");
    dn_step(0, "R2 down");
    dn_step(9, "R3 wrap down");
    dn_step(8, "R2 down");
    dn_step(7, "R2 down");
  endtask

  task automatic t_clear_override;
    load_val(4'd4);
    up_stb = 1'b0; clear = 1'b1; load_n = 1'b0; data_in = 4'd5;
    tick(3); check("R4 clear over load", count, 0);
    clear = 1'b0; load_n = 1'b1; tick(2);
    up_stb = 1'b1; tick(3); check("R8 step after clear", count, 1);
  endtask

  task automatic t_load_override;
    dn_stb = 1'b0; load_n = 1'b0; data_in = 4'd3; tick(3);
    check("R5 load over strobe", count, 3);
    load_n = 1'b1; tick(2);
    dn_stb = 1'b1; tick(3); check("R8 step after load", count, 2);
  endtask

  task automatic t_conflict;
    load_val(4'd5);
    up_stb = 1'b0; dn_stb = 1'b0; tick(3);
    up_stb = 1'b1; dn_stb = 1'b1; tick(4);
    check("R9 both rise", count, 5);
    dn_stb = 1'b0; tick(3);
    up_stb = 1'b0; tick(3);
    up_stb = 1'b1; tick(4);
    check("R9 up while down low", count, 5);
    dn_stb = 1'b1; tick(3);
    check("R2 down after release", count, 4);
  endtask

  task automatic t_nonbcd;
    load_val(4'd13);
    up_stb = 1'b0; dn_stb = 1'b0; tick(3);
    check("R10 carry at 13", carry_n, 1);
    check("R10 borrow at 13", borrow_n, 1);
    dn_stb = 1'b1; tick(3);
    up_stb = 1'b1; tick(3);
    check("R10 up from 13", count, 0);
    load_val(4'd10);
    dn_step(9, "R10 down from 10");
    load_val(4'd15);
    up_step(0, "R10 up from 15");
  endtask

  initial begin
    tick(3);
    rst = 1'b0; tick(1);
    t_reset();
    t_sequence();
    t_clear_override();
    t_load_override();
    t_conflict();
    t_nonbcd();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule